// File: doc/BRIEF.md
# Set/Clear Interrupt Mask and Priority Register Bank

This block holds a small set of interrupt control registers behind a flat word address space. Mask registers have two addresses. Writing the set address turns on the bits that are one in the written word. Writing the clear address turns those bits off. Priority registers have one address, and a write there replaces the whole value. Every register is split into equal fields, and each field controls one interrupt source. A mask field is one bit wide. A priority field is `PRIO_FW` bits wide.

Each accepted write starts a serial scan over the fields of the register it touched. The scan takes one field per clock. For each field whose value changed, the bank emits a one-cycle strobe carrying the source ID. The strobe is an enable if the new field value is nonzero and a disable if it is zero. A downstream source tracker consumes these strobes. `busy` stays high during the scan, and writes that arrive while `busy` is high are dropped. Reads are combinational and return the stored word of the addressed register.

Top module: `intmask_bank`

## Requirements
- R1: A write to the set address of mask register i (address 2*i) makes the stored value the OR of the old value and the written word.
- R2: A write to the clear address of mask register i (address 2*i+1) clears every stored bit that is one in the written word and leaves the other bits unchanged.
- R3: A write to priority register j (address 2*NUM_MASK+j, register number NUM_MASK+j) stores the written word unchanged.
- R4: Mask fields are 1 bit wide, giving REG_W fields. Priority fields are PRIO_FW bits wide, giving REG_W/PRIO_FW fields. Field 0 is the most significant slice, and later fields move toward bit 0. Field k of register number r belongs to source ID r*REG_W+k.
- R5: Field k is evaluated in the k-th cycle (counting from 0) after the clock edge that accepted the write. If its old and new values differ, `evt_valid` is high for that cycle with `evt_src_id` set to the field's source. `evt_enable` is 1 when the new field value is nonzero and 0 when it is zero. Unchanged fields produce no strobe.
- R6: A field whose source ID is 0 never produces a strobe, even when its value changes.
- R7: `rdata` is the stored word of the register addressed by `addr`, in the same cycle, for both the set and the clear address of a mask register. Unmapped addresses read as zero.
- R8: After an accepted write, `busy` is high for exactly as many cycles as the register has fields. A write presented while `busy` is high has no effect on the registers or the strobes.
- R9: After reset, all registers read zero, `busy` is low and no strobe is emitted.
- R10: A write to an unmapped address (2*NUM_MASK+NUM_PRIO or above) changes no register, does not raise `busy` and emits no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write request for the current cycle |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Stored value of the addressed register |
| busy | output | 1 | Field scan in progress; writes are ignored |
| evt_valid | output | 1 | One-cycle source enable/disable strobe |
| evt_enable | output | 1 | 1 = enable, 0 = disable, qualified by evt_valid |
| evt_src_id | output | ID_W | Source ID of the strobe |

## Verification
After the rising edge that accepts a write, the new register value appears on `rdata` in the following cycle. In that same cycle `busy` rises and the strobe for field 0 is due. The strobe for field k is due k cycles later, and `busy` falls once the last field's cycle has ended. The bench keeps a reference model with a queue of per-field strobe expectations. The model pushes the whole scan when it accepts a write and pops one entry on each rising edge. On every falling edge it compares `busy`, the strobe outputs and `rdata` against the queue head and its register copy, so every scan cycle and every idle cycle is checked. The stimulus includes back-to-back writes, writes to unmapped addresses, writes that change no field, and changes to the field tied to source 0.

// File: rtl/msk_bank_pkg.sv
package msk_bank_pkg;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_SET  = 2'd1,
    WK_CLR  = 2'd2,
    WK_LOAD = 2'd3
  } wr_kind_e;

  // Source identifier owned by field fld of register number reg_num.
  function automatic int unsigned src_id_calc(input int unsigned reg_num,
                                              input int unsigned fld,
                                              input int unsigned reg_w);
    return reg_num * reg_w + fld;
  endfunction

endpackage

// File: rtl/msk_bank_decode.sv
module msk_bank_decode
  import msk_bank_pkg::*;
#(
  parameter int unsigned NUM_MASK = 2,
  parameter int unsigned NUM_PRIO = 2,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output wr_kind_e          kind,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              is_prio
);

  localparam int unsigned MASK_SPAN = 2 * NUM_MASK;
  localparam int unsigned MAP_END   = MASK_SPAN + NUM_PRIO;

  int unsigned a;

  always_comb begin
    a       = int'(addr);
    kind    = WK_NONE;
    reg_idx = '0;
    is_prio = 1'b0;
    if (a < MASK_SPAN) begin
      // two addresses per mask register: even = set, odd = clear
      reg_idx = IDX_W'(a >> 1);
      kind    = addr[0] ? WK_CLR : WK_SET;
    end else if (a < MAP_END) begin
      reg_idx = IDX_W'(a - MASK_SPAN + NUM_MASK);
      kind    = WK_LOAD;
      is_prio = 1'b1;
    end
  end

endmodule

// File: rtl/msk_bank_store.sv
module msk_bank_store
  import msk_bank_pkg::*;
#(
  parameter int unsigned NREG  = 4,
  parameter int unsigned REG_W = 8,
  parameter int unsigned IDX_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_go,
  input  wr_kind_e                    kind,
  input  logic [IDX_W-1:0]            idx,
  input  logic [REG_W-1:0]            wdata,
  output logic [REG_W-1:0]            rdata,
  output logic [REG_W-1:0]            old_val,
  output logic [REG_W-1:0]            new_val,
  output logic [NREG-1:0][REG_W-1:0]  regs_flat
);

  logic [NREG-1:0][REG_W-1:0] regs_q;

  // next-state: merge of the write into the addressed register
  always_comb begin
    old_val = regs_q[idx];
    unique case (kind)
      WK_SET:  new_val = old_val | wdata;
      WK_CLR:  new_val = old_val & ~wdata;
      WK_LOAD: new_val = wdata;
      default: new_val = old_val;
    endcase
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic             hit;
    logic [REG_W-1:0] val_q;

    assign hit = wr_go && (idx == IDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (hit) begin
        val_q <= new_val;
      end
    end

    assign regs_q[r] = val_q;
  end

  assign rdata     = (kind != WK_NONE) ? regs_q[idx] : '0;
  assign regs_flat = regs_q;

  AST_SET_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && kind == WK_SET) |=> ((regs_q[$past(idx)] & $past(wdata)) == $past(wdata))); // R1

  AST_CLR_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && kind == WK_CLR) |=> ((regs_q[$past(idx)] & $past(wdata)) == '0)); // R2

  AST_PRIO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && kind == WK_LOAD) |=> (regs_q[$past(idx)] == $past(wdata))); // R3

endmodule

// File: rtl/msk_bank_scan.sv
module msk_bank_scan
  import msk_bank_pkg::*;
#(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned PRIO_FW = 4,
  parameter int unsigned ID_W    = 6,
  parameter int unsigned IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_prio,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [REG_W-1:0]  old_in,
  input  logic [REG_W-1:0]  new_in,
  output logic              busy,
  output logic              evt_valid,
  output logic              evt_enable,
  output logic [ID_W-1:0]   evt_src_id
);

  localparam int unsigned PRIO_NF = REG_W / PRIO_FW;
  localparam int unsigned CNT_W   = (REG_W > 1) ? $clog2(REG_W) : 1;

  logic              busy_q, busy_d;
  logic              prio_q, prio_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [REG_W-1:0]  old_q, old_d;
  logic [REG_W-1:0]  new_q, new_d;
  logic [CNT_W-1:0]  fld_q, fld_d;

  logic              last_fld;
  int unsigned       sh;
  logic [REG_W-1:0]  old_sh, new_sh;
  logic [PRIO_FW-1:0] f_old, f_new;

  assign last_fld = prio_q ? (fld_q == CNT_W'(PRIO_NF - 1)) : (fld_q == CNT_W'(REG_W - 1));

  // next-state
  always_comb begin
    busy_d = busy_q;
    prio_d = prio_q;
    idx_d  = idx_q;
    old_d  = old_q;
    new_d  = new_q;
    fld_d  = fld_q;
    if (start) begin
      busy_d = 1'b1;
      prio_d = start_prio;
      idx_d  = start_idx;
      old_d  = old_in;
      new_d  = new_in;
      fld_d  = '0;
    end else if (busy_q) begin
      if (last_fld) begin
        busy_d = 1'b0;
      end else begin
        fld_d = fld_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      prio_q <= 1'b0;
      idx_q  <= '0;
      old_q  <= '0;
      new_q  <= '0;
      fld_q  <= '0;
    end else begin
      busy_q <= busy_d;
      prio_q <= prio_d;
      idx_q  <= idx_d;
      old_q  <= old_d;
      new_q  <= new_d;
      fld_q  <= fld_d;
    end
  end

  // field extraction, field 0 at the top of the word
  always_comb begin
    sh     = prio_q ? int'(fld_q) * PRIO_FW : int'(fld_q);
    old_sh = old_q << sh;
    new_sh = new_q << sh;
    f_old  = prio_q ? old_sh[REG_W-1 -: PRIO_FW] : PRIO_FW'(old_sh[REG_W-1]);
    f_new  = prio_q ? new_sh[REG_W-1 -: PRIO_FW] : PRIO_FW'(new_sh[REG_W-1]);
  end

  assign evt_src_id = ID_W'(src_id_calc(int'(idx_q), int'(fld_q), REG_W));
  assign evt_valid  = busy_q && (f_old != f_new) && (evt_src_id != '0);
  assign evt_enable = |f_new;
  assign busy       = busy_q;

endmodule

// File: rtl/intmask_bank.sv
module intmask_bank
  import msk_bank_pkg::*;
#(
  parameter int unsigned NUM_MASK = 2,
  parameter int unsigned NUM_PRIO = 2,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned PRIO_FW  = 4,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned ID_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              busy,
  output logic              evt_valid,
  output logic              evt_enable,
  output logic [ID_W-1:0]   evt_src_id
);

  localparam int unsigned NREG  = NUM_MASK + NUM_PRIO;
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  wr_kind_e                   kind;
  logic [IDX_W-1:0]           reg_idx;
  logic                       is_prio;
  logic                       wr_go;
  logic [REG_W-1:0]           old_val, new_val;
  logic [NREG-1:0][REG_W-1:0] regs_flat;

  msk_bank_decode #(
    .NUM_MASK (NUM_MASK),
    .NUM_PRIO (NUM_PRIO),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr    (addr),
    .kind    (kind),
    .reg_idx (reg_idx),
    .is_prio (is_prio)
  );

  assign wr_go = wr_en && !busy && (kind != WK_NONE);

  msk_bank_store #(
    .NREG  (NREG),
    .REG_W (REG_W),
    .IDX_W (IDX_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_go     (wr_go),
    .kind      (kind),
    .idx       (reg_idx),
    .wdata     (wdata),
    .rdata     (rdata),
    .old_val   (old_val),
    .new_val   (new_val),
    .regs_flat (regs_flat)
  );

  msk_bank_scan #(
    .REG_W   (REG_W),
    .PRIO_FW (PRIO_FW),
    .ID_W    (ID_W),
    .IDX_W   (IDX_W)
  ) u_scan (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (wr_go),
    .start_prio (is_prio),
    .start_idx  (reg_idx),
    .old_in     (old_val),
    .new_in     (new_val),
    .busy       (busy),
    .evt_valid  (evt_valid),
    .evt_enable (evt_enable),
    .evt_src_id (evt_src_id)
  );

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_go |=> busy); // R8

  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && busy) |=> $stable(regs_flat)); // R8

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !busy && kind == WK_NONE) |=> (!busy && $stable(regs_flat))); // R10

  AST_STROBE_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n_s)
    evt_valid |-> busy); // R5

endmodule

// File: tb/intmask_bank_tb.sv
`timescale 1ns/1ps
module intmask_bank_tb;

  localparam int NM = 2;
  localparam int NP = 2;
  localparam int RW = 8;
  localparam int FW = 4;
  localparam int NR = NM + NP;
  localparam int MAPPED = 2 * NM + NP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy;
  logic       evt_valid;
  logic       evt_enable;
  logic [5:0] evt_src_id;

  always #2.5 clk = ~clk;

  intmask_bank u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .busy       (busy),
    .evt_valid  (evt_valid),
    .evt_enable (evt_enable),
    .evt_src_id (evt_src_id)
  );

  typedef struct { bit v; bit en; int id; } ev_t;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    chk_on = 0;
  bit    done = 0;
  string cur_tag = "R9";
  logic [7:0] mregs [NR];
  ev_t   evq [$];

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // reference model, advanced on the rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit was_busy;
      was_busy = evq.size() > 0;
      if (was_busy) void'(evq.pop_front());
      if (!was_busy && wr_en && int'(addr) < MAPPED) begin
        int a, r, fw, nf;
        bit prio;
        logic [7:0] ov, nv;
        a = int'(addr);
        prio = a >= 2 * NM;
        r = prio ? (a - 2 * NM + NM) : (a / 2);
        ov = mregs[r];
        if (prio) nv = wdata;
        else if (a % 2 == 0) nv = ov | wdata;
        else nv = ov & ~wdata;
        fw = prio ? FW : 1;
        nf = RW / fw;
        for (int k = 0; k < nf; k++) begin
          int fo, fn;
          ev_t e;
          fo = (int'(ov) >> (RW - fw * (k + 1))) & ((1 << fw) - 1);
          fn = (int'(nv) >> (RW - fw * (k + 1))) & ((1 << fw) - 1);
          e.id = r * RW + k;
          e.v  = (fo != fn) && (e.id != 0);
          e.en = fn != 0;
          evq.push_back(e);
        end
        mregs[r] = nv;
      end
    end
  end

  // comparison on the falling edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      int a, r, er;
      a = int'(addr);
      if (a < 2 * NM) r = a / 2;
      else r = a - 2 * NM + NM;
      er = (a < MAPPED) ? int'(mregs[r]) : 0;
      check({cur_tag, " R7 rdata"}, int'(rdata), er);
      check({cur_tag, " R8 busy"}, int'(busy), int'(evq.size() > 0));
      if (evq.size() > 0 && evq[0].v) begin
        check({cur_tag, " R5 evt_valid"}, int'(evt_valid), 1);
        check({cur_tag, " R5 evt_enable"}, int'(evt_enable), int'(evq[0].en));
        check({cur_tag, " R4 evt_src_id"}, int'(evt_src_id), evq[0].id);
      end else begin
        check({cur_tag, " R6 no strobe"}, int'(evt_valid), 0);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  task automatic put(input int a, input int d);
    @(posedge clk);
    #0.5;
    wr_en = 1'b1;
    addr  = 4'(a);
    wdata = 8'(d);
    @(posedge clk);
    #0.5;
    wr_en = 1'b0;
  endtask

  task automatic put_wait(input int a, input int d);
    put(a, d);
    idle(10);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) mregs[i] = '0;
    #12;
    rst_n = 1'b1;
    idle(4);
    chk_on = 1'b1;

    cur_tag = "R9";
    for (int a = 0; a < 8; a++) begin
      addr = 4'(a);
      idle(1);
    end

    cur_tag = "R1";
    put_wait(0, 8'hA5);
    put_wait(0, 8'h0F);
    put_wait(2, 8'h81);

    cur_tag = "R2";
    put_wait(1, 8'h81);
    put_wait(3, 8'hFF);

    cur_tag = "R7";
    put_wait(2, 8'h3C);
    addr = 4'd3;
    idle(2);
    addr = 4'd2;
    idle(2);

    cur_tag = "R3";
    put_wait(4, 8'h3C);
    put_wait(4, 8'h30);
    put_wait(4, 8'h00);

    cur_tag = "R4";
    put_wait(5, 8'h90);
    put_wait(5, 8'h97);

    cur_tag = "R6";
    put_wait(1, 8'h80);
    put_wait(0, 8'h80);

    cur_tag = "R8";
    put(0, 8'h40);
    put(0, 8'h02);
    put(4, 8'hFF);
    idle(10);
    put(4, 8'h11);
    put(5, 8'h22);
    idle(10);

    cur_tag = "R10";
    put_wait(9, 8'hFF);
    put_wait(15, 8'h55);

    cur_tag = "R5";
    put_wait(2, 8'h3C);
    for (int i = 0; i < 60; i++) begin
      put($urandom_range(0, 7), $urandom_range(0, 255));
      idle($urandom_range(0, 9));
    end
    idle(12);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule